// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static Memory

This block is a synthesizable model of a synchronous static memory that is accessed in bursts of four words. It has a reduced, parameterized depth and a word split into four byte lanes (nine bits each by default, so 36-bit words). Every control, address and write-data input is sampled on the rising clock edge. An access begins when one of two address strobes is asserted while the block is selected. A 2-bit beat counter then generates the two lowest address bits. An advance input steps the counter. A static mode input picks whether the counter steps in wrapping-add order or in XOR order.

Writes either fill the whole word or only the lanes whose select bits are low. Reads go through an address register and then an output register. Because of this, the output drivers stay on for one cycle after the block stops reading, and only then turn off. An output-enable input gates the drivers without waiting for a clock. A sleep input freezes the block: while it is high, the block does no access and holds its burst state.

The design is meant to stand in for an external burst memory in chip-level simulation, or to serve as a small on-die buffer that has the same cycle behaviour.

Top module: `burst_sram`

## Requirements
- R1: When `en_hi0`=1, `en_lo_n`=0 and `en_hi1`=1 at an edge, and `ctl_strb_n`=0 or `cpu_strb_n`=0, the block loads `addr` as the burst base, clears the beat counter and accesses `addr`. If either strobe is active while the block is not selected, the burst ends and nothing is accessed.
- R2: `cpu_strb_n` is ignored while `en_lo_n`=1. A burst started by `cpu_strb_n` always reads, whatever the write controls are.
- R3: With `ilv_mode`=0, each edge with `burst_adv_n`=0 and no strobe, during an active burst, increments the count and accesses `{base[AW-1:2], (base[1:0]+count) mod 4}`. The upper address bits do not change.
- R4: With `ilv_mode`=1, the advanced beat accesses `{base[AW-1:2], base[1:0] XOR count}`.
- R5: The count wraps to the start address after four beats. An edge with no strobe and `burst_adv_n`=1, during an active burst, accesses the current beat address again.
- R6: `wr_all_n`=0 writes all four lanes, whatever `wr_byte_n` and `lane_sel_n` are.
- R7: With `wr_all_n`=1 and `wr_byte_n`=0, only lane i (bits [i*LW +: LW]) with `lane_sel_n[i]`=0 is written. With both high, the access is a read.
- R8: Data read by an access at edge k appears on `rdata`, with `rdata_drv`=1 (when `out_en_n`=0), after edge k+1 and holds until edge k+2.
- R9: If edge k performs no read (deselect, write, idle or sleep), the drivers stay on until edge k+1 when edge k-1 did read. They are off after edge k+1.
- R10: `rdata_drv` follows `out_en_n` combinationally: it is low whenever `out_en_n`=1, without waiting for a clock.
- R11: While `sleep`=1, edges perform no read and no write, and the burst base and count are held.
- R12: During reset and after it, `rdata_drv`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | AW | External word address |
| en_hi0 | input | 1 | Chip enable, active high |
| en_lo_n | input | 1 | Chip enable, active low; also qualifies `cpu_strb_n` |
| en_hi1 | input | 1 | Chip enable, active high |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low, read only |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit i = lane i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby: blocks all access |
| ilv_mode | input | 1 | 1 = XOR burst order, 0 = linear burst order |
| wdata | input | 4*LW | Write data |
| rdata | output | 4*LW | Read data |
| rdata_drv | output | 1 | High when the data drivers are on |

## Verification
The assertions check on every cycle that a processor-strobe start never writes, that sleep cycles neither access nor move the burst state, that a selected strobe loads the base, and that the output drive follows the read request exactly two edges later. Burst orderings across the full wrap, the merge of lane writes into stored words, the combinational reaction to output enable, and the data returned through the pipeline depend on stored contents and on sequences of inputs, so only the bench's scenarios and its reference model can show them.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_READ,
    ACC_WRITE
  } acc_e;

  // Low address bits of a burst beat: XOR order or wrapping-add order.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       xor_order);
    return xor_order ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             en_hi0,
  input  logic             en_lo_n,
  input  logic             en_hi1,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             burst_adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             sleep,
  input  logic             ilv_mode,
  output logic [AW-1:0]    acc_addr,
  output logic [LANES-1:0] wr_lanes,
  output logic             rd_req
);

  logic          active_q, active_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          sel, cpu_go, ctl_go, wr_want;
  logic [LANES-1:0] lane_mask;
  acc_e          acc;

  always_comb begin
    sel       = en_hi0 & ~en_lo_n & en_hi1;
    cpu_go    = ~cpu_strb_n & ~en_lo_n;
    ctl_go    = ~ctl_strb_n;
    wr_want   = ~wr_all_n | ~wr_byte_n;
    lane_mask = ~wr_all_n ? {LANES{1'b1}} :
                (~wr_byte_n ? ~lane_sel_n : {LANES{1'b0}});

    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    acc      = ACC_NONE;
    acc_addr = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_q, ilv_mode)};

    if (!sleep) begin
      if (cpu_go || ctl_go) begin
        if (sel) begin
          active_d = 1'b1;
          base_d   = addr;
          cnt_d    = 2'd0;
          acc_addr = addr;
          acc      = (cpu_go || !wr_want) ? ACC_READ : ACC_WRITE;
        end else begin
          active_d = 1'b0;
        end
      end else if (active_q) begin
        if (!burst_adv_n) begin
          cnt_d    = cnt_q + 2'd1;
          acc_addr = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_d, ilv_mode)};
        end
        acc = wr_want ? ACC_WRITE : ACC_READ;
      end
    end

    wr_lanes = (acc == ACC_WRITE) ? lane_mask : {LANES{1'b0}};
    rd_req   = (acc == ACC_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= 2'd0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    base_q <= base_d;
  end

  // R2
  cpu_strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cpu_strb_n && !en_lo_n && en_hi0 && en_hi1) |-> (wr_lanes == '0 && rd_req));

  // R11
  sleep_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (wr_lanes == '0 && !rd_req));

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cnt_q) && $stable(active_q)));

  // R1
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && (!ctl_strb_n || (!cpu_strb_n && !en_lo_n)) && en_hi0 && !en_lo_n && en_hi1)
      |=> (active_q && cnt_q == 2'd0 && base_q == $past(addr)));

endmodule

// File: rtl/burst_array.sv
module burst_array #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LW    = 9,
  parameter int unsigned LANES = 4,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned DW    = LW * LANES
) (
  input  logic             clk,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) mem[wr_addr] <= wr_data[g*LW +: LW];
    end

    assign rd_data[g*LW +: LW] = mem[rd_addr];
  end

endmodule

// File: rtl/burst_rdpipe.sv
module burst_rdpipe #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          out_en_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_drv
);

  logic          a_v_q, a_v_d;
  logic [AW-1:0] a_addr_q, a_addr_d;
  logic          drv_q, drv_d;
  logic [DW-1:0] dout_q, dout_d;

  always_comb begin
    a_v_d    = rd_req;
    a_addr_d = rd_req ? rd_addr : a_addr_q;
    drv_d    = a_v_q;
    dout_d   = a_v_q ? arr_data : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      a_v_q <= a_v_d;
      drv_q <= drv_d;
    end
  end

  always_ff @(posedge clk) begin
    a_addr_q <= a_addr_d;
    dout_q   <= dout_d;
  end

  assign arr_addr  = a_addr_q;
  assign rdata     = dout_q;
  assign rdata_drv = drv_q & ~out_en_n;

  // R8
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> ##1 drv_q);

  // R9
  deselect_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> ##1 !drv_q);

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LW    = 9,
  localparam int unsigned LANES = 4,
  localparam int unsigned DW    = LW * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             en_hi0,
  input  logic             en_lo_n,
  input  logic             en_hi1,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             burst_adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             out_en_n,
  input  logic             sleep,
  input  logic             ilv_mode,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_drv
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [AW-1:0]    acc_addr, arr_addr;
  logic [LANES-1:0] wr_lanes;
  logic             rd_req;
  logic [DW-1:0]    arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  burst_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .addr(addr),
    .en_hi0(en_hi0), .en_lo_n(en_lo_n), .en_hi1(en_hi1),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .sleep(sleep), .ilv_mode(ilv_mode),
    .acc_addr(acc_addr), .wr_lanes(wr_lanes), .rd_req(rd_req)
  );

  burst_array #(.AW(AW), .LW(LW), .LANES(LANES)) u_array (
    .clk(clk), .wr_lanes(wr_lanes), .wr_addr(acc_addr), .wr_data(wdata),
    .rd_addr(arr_addr), .rd_data(arr_data)
  );

  burst_rdpipe #(.AW(AW), .DW(DW)) u_pipe (
    .clk(clk), .rst_n(rst_core_n), .rd_req(rd_req), .rd_addr(acc_addr),
    .arr_addr(arr_addr), .arr_data(arr_data), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int AW = 6, LW = 9, DW = 36, DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic en_hi0, en_lo_n, en_hi1, cpu_strb_n, ctl_strb_n, burst_adv_n;
  logic wr_all_n, wr_byte_n, out_en_n, sleep, ilv_mode;
  logic [3:0] lane_sel_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_drv;

  burst_sram #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_hi0(en_hi0), .en_lo_n(en_lo_n),
    .en_hi1(en_hi1), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
    .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep),
    .ilv_mode(ilv_mode), .wdata(wdata), .rdata(rdata), .rdata_drv(rdata_drv)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] mem_m [DEPTH];
  logic          m_act, m_av, m_drv;
  logic [AW-1:0] m_base, m_aaddr;
  logic [1:0]    m_cnt;
  logic [DW-1:0] m_dout;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a) * 36'h0_1357_9BDF ^ 36'hA_C0FF_EE11;
  endfunction

  function automatic logic [1:0] low_of(input logic [1:0] s, input logic [1:0] c, input logic x);
    return x ? (s ^ c) : (s + c);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic sel, pgo, cgo, wrq, rd, wr, nd;
    logic [3:0] mask;
    logic [AW-1:0] a;
    logic [DW-1:0] ndo;
    sel  = en_hi0 & ~en_lo_n & en_hi1;
    pgo  = ~cpu_strb_n & ~en_lo_n;
    cgo  = ~ctl_strb_n;
    wrq  = ~wr_all_n | ~wr_byte_n;
    mask = ~wr_all_n ? 4'hF : (~wr_byte_n ? ~lane_sel_n : 4'h0);
    nd   = m_av;
    ndo  = m_av ? mem_m[m_aaddr] : m_dout;
    rd = 0; wr = 0; a = '0;
    if (!sleep) begin
      if (pgo || cgo) begin
        if (sel) begin
          m_act = 1; m_base = addr; m_cnt = 0; a = addr;
          if (pgo || !wrq) rd = 1; else wr = 1;
        end else m_act = 0;
      end else if (m_act) begin
        if (!burst_adv_n) m_cnt = m_cnt + 2'd1;
        a  = {m_base[AW-1:2], low_of(m_base[1:0], m_cnt, ilv_mode)};
        rd = !wrq; wr = wrq;
      end
    end
    if (wr) for (int i = 0; i < 4; i++) if (mask[i]) mem_m[a][i*LW +: LW] = wdata[i*LW +: LW];
    if (rd) m_aaddr = a;
    m_av = rd; m_drv = nd; m_dout = ndo;
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(rdata_drv == (m_drv & ~out_en_n), req, "drive", {35'd0, rdata_drv}, {35'd0, m_drv & ~out_en_n});
    if (m_drv && !out_en_n) chk(rdata == m_dout, req, "data", rdata, m_dout);
  endtask

  task automatic idle();
    en_hi0 = 1; en_lo_n = 0; en_hi1 = 1; cpu_strb_n = 1; ctl_strb_n = 1;
    burst_adv_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_sel_n = 4'hF;
    out_en_n = 0; sleep = 0;
  endtask

  task automatic deselect(input string req);
    idle(); ctl_strb_n = 0; en_hi0 = 0;
    tick(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int beat_a[5];
    logic [DW-1:0] e;
    void'($urandom(32'd4242));
    idle(); ilv_mode = 0; addr = '0; wdata = '0;
    m_act = 0; m_av = 0; m_drv = 0; m_cnt = 0; m_base = '0; m_aaddr = '0; m_dout = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(rdata_drv == 0, "R12", "drive in reset", {35'd0, rdata_drv}, '0);
    rst_n = 1;
    repeat (3) tick("R12");
    chk(rdata_drv == 0, "R12", "drive after reset", {35'd0, rdata_drv}, '0);

    // fill every word with a global write burst start (R6)
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctl_strb_n = 0; addr = AW'(a); wr_all_n = 0; wr_byte_n = 1;
      lane_sel_n = 4'hF; wdata = pat(a);
      tick("R6");
    end
    deselect("R1");

    // linear burst from 6: 6,7,4,5 (R3)
    beat_a = '{6, 7, 4, 5, 6};
    idle(); ilv_mode = 0; ctl_strb_n = 0; addr = 6'd6; tick("R3");
    for (int b = 1; b < 4; b++) begin
      idle(); burst_adv_n = 0; tick("R3");
      chk(rdata == pat(beat_a[b-1]), "R3", "linear beat", rdata, pat(beat_a[b-1]));
    end
    deselect("R9");
    chk(rdata == pat(beat_a[3]), "R3", "linear last beat", rdata, pat(beat_a[3]));
    chk(rdata_drv == 1, "R9", "drive held one cycle", {35'd0, rdata_drv}, 36'd1);
    idle(); tick("R9");
    chk(rdata_drv == 0, "R9", "drive off", {35'd0, rdata_drv}, '0);

    // XOR burst from 9 with wrap: 9,8,11,10,9 (R4, R5)
    beat_a = '{9, 8, 11, 10, 9};
    idle(); ilv_mode = 1; ctl_strb_n = 0; addr = 6'd9; tick("R4");
    for (int b = 1; b < 5; b++) begin
      idle(); ilv_mode = 1; burst_adv_n = 0; tick("R4");
      chk(rdata == pat(beat_a[b-1]), "R4", "xor beat", rdata, pat(beat_a[b-1]));
    end
    idle(); ilv_mode = 1; tick("R5");
    chk(rdata == pat(beat_a[4]), "R5", "wrapped beat", rdata, pat(beat_a[4]));
    idle(); ilv_mode = 1; tick("R5");
    chk(rdata == pat(beat_a[4]), "R5", "suspend repeats", rdata, pat(beat_a[4]));
    deselect("R9");

    // per-lane write at 20, lanes 0 and 2 (R7)
    idle(); ilv_mode = 0; ctl_strb_n = 0; addr = 6'd20; wr_byte_n = 0;
    lane_sel_n = 4'b1010; wdata = '1; tick("R7");
    idle(); ctl_strb_n = 0; addr = 6'd20; tick("R7");
    deselect("R7");
    e = pat(20); e[0 +: LW] = '1; e[2*LW +: LW] = '1;
    chk(rdata == e, "R7", "lane merge", rdata, e);

    // global write overrides disabled lanes (R6)
    idle(); ctl_strb_n = 0; addr = 6'd40; wr_all_n = 0; wr_byte_n = 1;
    lane_sel_n = 4'hF; wdata = 36'h1_2345_6789; tick("R6");
    idle(); ctl_strb_n = 0; addr = 6'd40; tick("R6");
    deselect("R6");
    chk(rdata == 36'h1_2345_6789, "R6", "global write", rdata, 36'h1_2345_6789);

    // processor strobe ignored while en_lo_n high, and always reads (R2)
    idle(); en_lo_n = 1; cpu_strb_n = 0; burst_adv_n = 0; tick("R2");
    tick("R2");
    chk(rdata_drv == 0, "R2", "strobe ignored", {35'd0, rdata_drv}, '0);
    idle(); cpu_strb_n = 0; addr = 6'd30; wr_all_n = 0; wdata = '0; tick("R2");
    deselect("R2");
    chk(rdata == pat(30), "R2", "processor start reads", rdata, pat(30));
    idle(); tick("R2");

    // sleep blocks access and holds the burst (R11)
    idle(); ctl_strb_n = 0; addr = 6'd12; tick("R11");
    idle(); sleep = 1; burst_adv_n = 0; wr_all_n = 0; wdata = '0; tick("R11");
    tick("R11");
    chk(rdata_drv == 0, "R11", "no read in sleep", {35'd0, rdata_drv}, '0);
    idle(); burst_adv_n = 0; tick("R11");
    deselect("R11");
    chk(rdata == pat(13), "R11", "count held", rdata, pat(13));
    idle(); cpu_strb_n = 0; addr = 6'd12; tick("R11");
    deselect("R11");
    chk(rdata == pat(12), "R11", "no write in sleep", rdata, pat(12));

    // asynchronous output enable (R10)
    idle(); tick("R10");
    idle(); cpu_strb_n = 0; addr = 6'd5; tick("R8");
    deselect("R8");
    chk(rdata_drv == 1 && rdata == pat(5), "R8", "read latency", rdata, pat(5));
    #3 out_en_n = 1;
    #1 chk(rdata_drv == 0, "R10", "oe off", {35'd0, rdata_drv}, '0);
    out_en_n = 0;
    #1 chk(rdata_drv == 1, "R10", "oe on", {35'd0, rdata_drv}, 36'd1);
    idle(); tick("R10");

    // constrained random traffic against the model (R8)
    for (int c = 0; c < 3000; c++) begin
      if (c % 100 == 0) ilv_mode = 1'($urandom % 2);
      en_hi0 = ($urandom % 8) != 0; en_lo_n = ($urandom % 8) == 0; en_hi1 = ($urandom % 8) != 0;
      cpu_strb_n = ($urandom % 5) != 0; ctl_strb_n = ($urandom % 5) != 0;
      burst_adv_n = 1'($urandom % 2);
      wr_all_n = ($urandom % 4) != 0; wr_byte_n = 1'($urandom % 2);
      lane_sel_n = 4'($urandom); sleep = ($urandom % 20) == 0;
      out_en_n = ($urandom % 6) == 0;
      addr = AW'($urandom); wdata = {4'($urandom), 32'($urandom)};
      tick("R8");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule